// File: doc/BRIEF.md
# HSYNC Jitter One-Shot Phase Corrector

This block sits inside an all-digital pixel-clock PLL. It applies a one-line correction to the oscillator tuning code each time a horizontal sync edge arrives. Two time-to-digital paths measure the sync edge. One reports how far the edge leads and the other how far it lags. The block turns these readings into one signed error and multiplies it by a programmable loop gain. The result is an offset in fine DCO steps with a 6-bit fraction.

For exactly one line of pixel clocks, the integer part of that offset is added to the code from the loop filter. A first-order sigma-delta modulator spreads the fractional part over the same line. The phase error caused by the jittered edge is therefore paid back before the next sync. After the line the offset returns to zero, so the average frequency is unchanged.

The loop-filter code, the line length in pixels and the gain all come from outside the block. The sync input is asynchronous and is synchronised inside the block. Everything else runs in the pixel clock domain.

Top module: `hjc_line_corrector`

## Requirements
- R1: The signed error is +lead when `tdc_lead` is nonzero, else −lag when `tdc_lag` is nonzero, else zero. Lead takes priority when both are nonzero. A zero error leaves `dco_code` equal to `lf_code` through the whole line.
- R2: `gain` is unsigned, with 2 integer bits and 6 fraction bits. The product p = error × gain is in 1/64 fine steps. The integer offset is floor(p/64) and the fraction is p mod 64, in the range 0..63.
- R3: The first corrected `dco_code` value is registered on the 4th rising clock edge after `hsync_in` goes high. After the 3rd edge the output still equals `lf_code`.
- R4: The correction lasts exactly `line_len` clock cycles. After that, `dco_code` equals `lf_code` again.
- R5: During the line, every output is either `lf_code` + integer offset or `lf_code` + integer offset + 1. The number of +1 cycles over the line equals floor(`line_len` × fraction / 64), because the modulator accumulator is cleared at each sync edge.
- R6: The corrected code saturates at 0 and at 2^CODE_W−1 and never wraps.
- R7: A sync edge that arrives while a correction is running replaces the old offset rather than adding to it. It also restarts the line count and the modulator.
- R8: With no correction active, `dco_code` follows `lf_code` one cycle later.
- R9: While `rst` is high, `dco_code` is 0 and no correction is pending.
- R10: A sync edge with `line_len` = 0 produces no correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Asynchronous horizontal sync; the rising edge starts a correction |
| tdc_lead | input | 6 | Lead-path converter code, sampled at the detected edge |
| tdc_lag | input | 6 | Lag-path converter code, sampled at the detected edge |
| gain | input | 8 | Loop gain, unsigned, 2 integer and 6 fraction bits |
| line_len | input | 12 | Pixels per line; the correction length in clocks |
| lf_code | input | 10 | Loop-filter DCO code |
| dco_code | output | 10 | Registered, corrected DCO code |

## Verification
The sync edge passes through two synchroniser flops and one edge-detect flop, and the sum then goes through the output register. The first corrected code is therefore due on the 4th clock edge after `hsync_in` rises. The bench samples on the falling edge after the 3rd clock edge and expects the plain filter code there. It then collects exactly `line_len` samples, one per falling edge, and expects the plain code again on the sample that follows. Changes to `lf_code` while idle are expected on the very next sample. For an early sync edge, the old offset is expected for three more samples, and the new offset starts on the fourth.

// File: rtl/hjc_pkg.sv
package hjc_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_LEAD = 2'd1,
    ERR_LAG  = 2'd2
  } err_src_e;
endpackage

// File: rtl/hjc_err_former.sv
module hjc_err_former
  import hjc_pkg::*;
#(
  parameter int TDC_W = 6
) (
  input  logic [TDC_W-1:0]      lead_code,
  input  logic [TDC_W-1:0]      lag_code,
  output logic signed [TDC_W:0] err,
  output err_src_e              src
);
  always_comb begin
    if (lead_code != '0) begin
      err = $signed({1'b0, lead_code});
      src = ERR_LEAD;
    end else if (lag_code != '0) begin
      err = -$signed({1'b0, lag_code});
      src = ERR_LAG;
    end else begin
      err = '0;
      src = ERR_NONE;
    end
  end
endmodule

// File: rtl/hjc_scaler.sv
module hjc_scaler #(
  parameter int TDC_W  = 6,
  parameter int GAIN_W = 8,
  parameter int FRAC_W = 6,
  parameter int INT_W  = TDC_W + GAIN_W + 2 - FRAC_W
) (
  input  logic signed [TDC_W:0]   err,
  input  logic [GAIN_W-1:0]       gain,
  output logic signed [INT_W-1:0] ofs_int,
  output logic [FRAC_W-1:0]       ofs_frac
);
  localparam int PROD_W = TDC_W + GAIN_W + 2;

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod     = PROD_W'(err) * PROD_W'($signed({1'b0, gain}));
    ofs_int  = prod[PROD_W-1:FRAC_W];
    ofs_frac = prod[FRAC_W-1:0];
  end
endmodule

// File: rtl/hjc_sd_dither.sv
module hjc_sd_dither #(
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_nxt;
  logic              ovf;

  always_comb begin
    {ovf, acc_nxt} = {1'b0, acc_q} + {1'b0, frac};
    carry          = en & ovf;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (en)    acc_q <= acc_nxt;
  end

  // R5: the accumulator moves only while the line is active
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc_q));
  // R5: a zero fraction never yields a carry
  a_r5_zero_frac: assert property (@(posedge clk) disable iff (rst)
    (frac == '0) |-> !carry);
endmodule

// File: rtl/hjc_line_corrector.sv
module hjc_line_corrector
  import hjc_pkg::*;
#(
  parameter int TDC_W  = 6,
  parameter int GAIN_W = 8,
  parameter int FRAC_W = 6,
  parameter int CODE_W = 10,
  parameter int LINE_W = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_in,
  input  logic [TDC_W-1:0]  tdc_lead,
  input  logic [TDC_W-1:0]  tdc_lag,
  input  logic [GAIN_W-1:0] gain,
  input  logic [LINE_W-1:0] line_len,
  input  logic [CODE_W-1:0] lf_code,
  output logic [CODE_W-1:0] dco_code
);
  localparam int INT_W = TDC_W + GAIN_W + 2 - FRAC_W;
  localparam int SUM_W = CODE_W + INT_W + 1;
  localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((64'd1 << CODE_W) - 64'd1);

  // sync edge: SYNC_N synchroniser flops plus one edge flop
  logic [SYNC_N:0] sync_q;
  logic            rise;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-1:0], hsync_in};
  end
  assign rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

  // error and scaling
  logic signed [TDC_W:0]   err;
  err_src_e                src;
  logic signed [INT_W-1:0] ofs_int;
  logic [FRAC_W-1:0]       ofs_frac;

  hjc_err_former #(.TDC_W(TDC_W)) u_err (
    .lead_code(tdc_lead), .lag_code(tdc_lag), .err(err), .src(src));

  hjc_scaler #(.TDC_W(TDC_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_scl (
    .err(err), .gain(gain), .ofs_int(ofs_int), .ofs_frac(ofs_frac));

  // offset latch and line counter
  logic signed [INT_W-1:0] ofs_int_q;
  logic [FRAC_W-1:0]       ofs_frac_q;
  logic                    active_q;
  logic [LINE_W-1:0]       cnt_q;
  logic [LINE_W-1:0]       last_idx;

  assign last_idx = line_len - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_int_q  <= '0;
      ofs_frac_q <= '0;
      active_q   <= 1'b0;
      cnt_q      <= '0;
    end else if (rise) begin
      ofs_int_q  <= ofs_int;
      ofs_frac_q <= ofs_frac;
      active_q   <= (line_len != '0);
      cnt_q      <= '0;
    end else if (active_q) begin
      if (cnt_q == last_idx) active_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // fractional dither
  logic carry;

  hjc_sd_dither #(.FRAC_W(FRAC_W)) u_sd (
    .clk(clk), .rst(rst), .clr(rise), .en(active_q),
    .frac(ofs_frac_q), .carry(carry));

  // sum, saturate, register
  logic signed [SUM_W-1:0] sum;
  logic [CODE_W-1:0]       sat;

  always_comb begin
    sum = $signed({{(SUM_W-CODE_W){1'b0}}, lf_code});
    if (active_q)
      sum = sum + {{(SUM_W-INT_W){ofs_int_q[INT_W-1]}}, ofs_int_q}
                + $signed({{(SUM_W-1){1'b0}}, carry});
    if (sum < 0)             sat = '0;
    else if (sum > CODE_MAX) sat = CODE_MAX[CODE_W-1:0];
    else                     sat = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) dco_code <= '0;
    else     dco_code <= sat;
  end

  // R4: the counter never passes the programmed line length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < line_len));
  // R8: idle output follows the filter code one cycle later
  a_r8_idle_track: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> (dco_code == $past(lf_code)));
  // R6: a positive offset never drops the code below the filter code
  a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (active_q && !ofs_int_q[INT_W-1]) |=> (dco_code >= $past(lf_code)));
  // R6: a negative offset never lifts the code above the filter code
  a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (active_q && ofs_int_q[INT_W-1] && !carry) |=> (dco_code < $past(lf_code)
      || $past(lf_code) == '0));
  // R10: a zero line length starts no correction
  a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
    (rise && line_len == '0) |=> !active_q);
  // R1: no error source latches a zero offset
  a_r1_none_zero: assert property (@(posedge clk) disable iff (rst)
    (rise && src == ERR_NONE) |=> (ofs_int_q == '0 && ofs_frac_q == '0));
endmodule

// File: tb/hjc_line_corrector_bench.sv
module hjc_line_corrector_bench;
  localparam int CODE_MAX = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_in = 1'b0;
  logic [5:0]  tdc_lead = '0;
  logic [5:0]  tdc_lag = '0;
  logic [7:0]  gain = '0;
  logic [11:0] line_len = 12'd16;
  logic [9:0]  lf_code = '0;
  logic [9:0]  dco_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hjc_line_corrector u_hjc_line_corrector (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .tdc_lead(tdc_lead),
    .tdc_lag(tdc_lag), .gain(gain), .line_len(line_len),
    .lf_code(lf_code), .dco_code(dco_code));

  function automatic int exp_err(int ld, int lg);
    if (ld != 0) return ld;
    if (lg != 0) return -lg;
    return 0;
  endfunction

  function automatic int clampc(int v);
    if (v < 0) return 0;
    if (v > CODE_MAX) return CODE_MAX;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // samples n falling edges; each output must be lo or hi, carries counted
  task automatic window(int lf, int oi, int fr, int n, bit cnt_chk, string req);
    int lo = clampc(lf + oi);
    int hi = clampc(lf + oi + 1);
    int carries = 0;
    int nbad = 0;
    int first = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dco_code == hi && hi != lo) carries++;
      else if (dco_code != lo) begin
        if (nbad == 0) first = dco_code;
        nbad++;
      end
    end
    check(nbad == 0, req, first, lo);
    if (cnt_chk && hi != lo)
      check(carries == (n * fr) / 64, "R5 carry count", carries, (n * fr) / 64);
  endtask

  task automatic line_test(int ld, int lg, int g, int lf, int len, string req);
    int p = exp_err(ld, lg) * g;
    int oi = p >>> 6;
    int fr = p & 63;
    @(negedge clk);
    tdc_lead = 6'(ld); tdc_lag = 6'(lg); gain = 8'(g);
    lf_code = 10'(lf); line_len = 12'(len);
    hsync_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dco_code == 10'(lf), "R3 before first corrected edge", dco_code, lf);
    hsync_in = 1'b0;
    if (len == 0) window(lf, 0, 0, 8, 0, "R10 zero length");
    else begin
      window(lf, oi, fr, len, 1, req);
      @(negedge clk);
      check(dco_code == 10'(lf), "R4 offset removed after line", dco_code, lf);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    check(dco_code == 0, "R9 reset value", dco_code, 0);
    lf_code = 10'd500;
    @(negedge clk);
    check(dco_code == 0, "R9 held in reset", dco_code, 0);
    rst = 1'b0;
    @(negedge clk);
    check(dco_code == 10'd500, "R8 idle follows filter", dco_code, 500);
    lf_code = 10'd321;
    @(negedge clk);
    check(dco_code == 10'd321, "R8 one cycle later", dco_code, 321);

    line_test(10, 0, 64, 400, 32, "R1 lead positive");
    line_test(0, 7, 64, 400, 32, "R1 lag negative");
    line_test(5, 9, 64, 400, 20, "R1 lead wins");
    line_test(0, 0, 200, 400, 20, "R1 zero error");
    line_test(1, 0, 37, 300, 64, "R2 fraction only");
    line_test(0, 1, 1, 300, 64, "R2 negative floor");
    line_test(3, 0, 100, 300, 50, "R2 mixed");
    line_test(63, 0, 255, 1000, 24, "R6 saturate high");
    line_test(0, 63, 255, 5, 24, "R6 saturate low");
    line_test(20, 0, 64, 300, 0, "R10 zero length");

    // R7: early sync replaces offset A with offset B
    @(negedge clk);
    tdc_lead = 6'd10; tdc_lag = 0; gain = 8'd64; lf_code = 10'd500; line_len = 12'd40;
    hsync_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    hsync_in = 1'b0;
    window(500, 10, 0, 5, 0, "R7 first offset");
    tdc_lead = 0; tdc_lag = 6'd3; gain = 8'd90;
    hsync_in = 1'b1;
    window(500, 10, 0, 3, 0, "R7 old offset until new edge");
    hsync_in = 1'b0;
    window(500, (-270) >>> 6, (-270) & 63, 40, 1, "R7 replaced offset");
    @(negedge clk);
    check(dco_code == 10'd500, "R7 R4 removed after restart", dco_code, 500);
    repeat (3) @(negedge clk);

    for (int k = 0; k < 25; k++) begin
      int ld = ($urandom % 3 == 0) ? 0 : int'($urandom % 64);
      int lg = int'($urandom % 64);
      line_test(ld, lg, int'($urandom % 256), int'($urandom % 1024),
                8 + int'($urandom % 60), "R5 random line");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule